// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in in pure combinational logic, returning a 16-bit sum and a carry-out. It is meant for datapaths where the carry path sets the cycle time and a plain ripple chain is too slow.

The operand width is cut into four 4-bit slices. Each slice forms per-bit propagate (OR of the operand bits) and generate (AND of the operand bits). It derives its own internal carries as flat sum-of-products terms, so they do not chain. It also reports a group propagate and a group generate. A second lookahead level takes the four group pairs and the carry-in, and produces the carry into every slice and the final carry-out in the same flat form. Nothing ripples from one slice to the next, and no slice forms a carry-out of its own.

A ripple-carry adder with the same ports comes with the block as a golden model that the bench can compare against.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, {carry_out, sum_out} equals the 17-bit value a_in + b_in + carry_in.
- R2: Each sum bit is a XOR b XOR the carry into that bit. A bit pair with both ones therefore yields a sum bit equal to its incoming carry: 0x0001 + 0x0001 with carry_in 0 gives sum 0x0002.
- R3: When exactly one operand bit is 1 in every position (a_in XOR b_in = 0xFFFF), the carry-in passes through all slices. The sum is 0xFFFF when carry_in is 0 and 0x0000 when carry_in is 1, and carry_out equals carry_in.
- R4: A carry generated in bit 0 crosses every higher slice that only propagates: 0xFFFF + 0x0001 with carry_in 0 gives sum 0x0000 and carry_out 1.
- R5: When bit 15 of both operands is 1, carry_out is 1 whatever carry_in and the lower bits are.
- R6: When bit 15 of both operands is 0, carry_out is 0 whatever carry_in and the lower bits are.
- R7: The carry into slice k+1 (bits 4k+4 and up) is that slice's group generate, or its group propagate ANDed with the carry into slice k. For example, 0x00F0 + 0x0010 gives 0x0100.
- R8: The ripple-carry golden model returns the same {carry, sum} as the lookahead adder for every input.
- R9: Extremes: 0xFFFF + 0xFFFF + 1 gives carry_out 1 and sum 0xFFFF. 0 + 0 + 0 gives carry_out 0 and sum 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15, from the second lookahead level |

## Verification
The assertions rely on the operand and carry inputs being settled, two-valued levels whenever the combinational checker evaluates. The slice-carry and pass-through checks also assume that group propagate is the AND of the per-bit ORs, so a group can show propagate and generate at once. The bench changes inputs only just after a rising clock edge and reads results at the falling edge, so no check sees a half-updated operand. Every input is a concrete 0/1 vector, from the replicated-byte sweep, the corner list or a linear-congruential sequence.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int MAXN = 32;

  // Carry into position j, written as a flat OR of AND terms over positions below j.
  function automatic logic la_carry(input logic [MAXN-1:0] p, input logic [MAXN-1:0] g,
                                    input logic c0, input int j);
    logic res;
    logic term;
    res = 1'b0;
    for (int k = 0; k < j; k++) begin
      term = g[k];
      for (int m = k + 1; m < j; m++) term = term & p[m];
      res = res | term;
    end
    term = c0;
    for (int m = 0; m < j; m++) term = term & p[m];
    return res | term;
  endfunction

  function automatic logic grp_generate(input logic [MAXN-1:0] p, input logic [MAXN-1:0] g,
                                        input int n);
    return la_carry(p, g, 1'b0, n);
  endfunction

  function automatic logic grp_propagate(input logic [MAXN-1:0] p, input int n);
    return la_carry(p, '0, 1'b1, n);
  endfunction
endpackage

// File: rtl/pg_stage.sv
module pg_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g,
  output logic [W-1:0] x
);
  assign p = a | b;
  assign g = a & b;
  assign x = a ^ b;
endmodule

// File: rtl/lookahead_unit.sv
module lookahead_unit #(
  parameter int N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         c_in,
  output logic [N-1:0] carry_o
);
  localparam int PAD = cla_pkg::MAXN - N;

  logic [cla_pkg::MAXN-1:0] p_ext;
  logic [cla_pkg::MAXN-1:0] g_ext;

  assign p_ext = {{PAD{1'b0}}, p};
  assign g_ext = {{PAD{1'b0}}, g};

  // carry_o[j-1] is the carry into position j
  for (genvar j = 1; j <= N; j++) begin : g_carry
    assign carry_o[j-1] = cla_pkg::la_carry(p_ext, g_ext, c_in, j);
  end
endmodule

// File: rtl/group_pg.sv
module group_pg #(
  parameter int N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  output logic         gp,
  output logic         gg
);
  localparam int PAD = cla_pkg::MAXN - N;

  assign gp = cla_pkg::grp_propagate({{PAD{1'b0}}, p}, N);
  assign gg = cla_pkg::grp_generate({{PAD{1'b0}}, p}, {{PAD{1'b0}}, g}, N);
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         grp_p,
  output logic         grp_g
);
  logic [W-1:0] p;
  logic [W-1:0] g;
  logic [W-1:0] x;
  logic [W-1:0] c;
  logic [W-2:0] inner;

  pg_stage #(.W(W)) pg_i (
    .a(a), .b(b), .p(p), .g(g), .x(x)
  );

  // Only the carries into bits 1..W-1 are built; no local carry-out is formed.
  lookahead_unit #(.N(W-1)) la_i (
    .p(p[W-2:0]), .g(g[W-2:0]), .c_in(cin), .carry_o(inner)
  );

  group_pg #(.N(W)) grp_i (
    .p(p), .g(g), .gp(grp_p), .gg(grp_g)
  );

  assign c   = {inner, cin};
  assign sum = x ^ c;
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i] = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end
  assign cout = c[W];
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int WIDTH = 16,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int NSLICE = WIDTH / SLICE;

  logic [NSLICE-1:0] slice_p;
  logic [NSLICE-1:0] slice_g;
  logic [NSLICE:0]   slice_cin;
  logic [NSLICE-1:0] upper_c;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    cla_slice #(.W(SLICE)) slice_i (
      .a    (a_in[k*SLICE +: SLICE]),
      .b    (b_in[k*SLICE +: SLICE]),
      .cin  (slice_cin[k]),
      .sum  (sum_out[k*SLICE +: SLICE]),
      .grp_p(slice_p[k]),
      .grp_g(slice_g[k])
    );
  end

  lookahead_unit #(.N(NSLICE)) top_la_i (
    .p(slice_p), .g(slice_g), .c_in(carry_in), .carry_o(upper_c)
  );

  assign slice_cin = {upper_c, carry_in};
  assign carry_out = slice_cin[NSLICE];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int WIDTH = 16,
  parameter int SLICE = 4
) (
  input logic [WIDTH-1:0]        a_in,
  input logic [WIDTH-1:0]        b_in,
  input logic                    carry_in,
  input logic [WIDTH-1:0]        sum_out,
  input logic                    carry_out,
  input logic [WIDTH/SLICE-1:0]  slice_p,
  input logic [WIDTH/SLICE-1:0]  slice_g,
  input logic [WIDTH/SLICE:0]    slice_cin
);
  localparam int NS = WIDTH / SLICE;

  always_comb begin
    // R1
    sum_chk: assert ({carry_out, sum_out} ==
                     ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in}))
      else $error("R1 sum mismatch");
    for (int k = 0; k < NS; k++) begin
      // R7
      slice_carry_chk: assert (slice_cin[k+1] == (slice_g[k] | (slice_p[k] & slice_cin[k])))
        else $error("R7 slice carry %0d", k);
    end
    // R3
    prop_pass_chk: assert (!((&slice_p) && !(|slice_g)) || carry_out == carry_in)
      else $error("R3 pass-through");
    // R5
    top_gen_chk: assert (!(a_in[WIDTH-1] && b_in[WIDTH-1]) || carry_out)
      else $error("R5 top generate");
    // R6
    top_kill_chk: assert (a_in[WIDTH-1] || b_in[WIDTH-1] || !carry_out)
      else $error("R6 top kill");
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH), .SLICE(SLICE)) chk_i (
  .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .sum_out(sum_out),
  .carry_out(carry_out), .slice_p(slice_p), .slice_g(slice_g), .slice_cin(slice_cin)
);

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb_top;
  logic        clk = 1'b0;
  logic [15:0] a, b, s, rs;
  logic        ci, co, rco;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cla_adder16 dut_i (.a_in(a), .b_in(b), .carry_in(ci), .sum_out(s), .carry_out(co));
  ripple_adder #(.W(16)) ref_i (.a(a), .b(b), .cin(ci), .sum(rs), .cout(rco));

  task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h ci=%b got=%h exp=%h", tag, a, b, ci, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic cv,
                       input string tag);
    logic [16:0] exp;
    @(posedge clk);
    a = av; b = bv; ci = cv;
    exp = 17'(av) + 17'(bv) + 17'(cv);
    @(negedge clk);
    check(tag, {co, s}, exp);
    check("R8", {rco, rs}, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] lcg;
    a = '0; b = '0; ci = 1'b0;
    // R9 reset-level zero state
    apply(16'h0000, 16'h0000, 1'b0, "R9");
    check("R9", {co, s}, 17'h0_0000);
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R9");
    check("R9", {co, s}, 17'h1_FFFF);
    apply(16'h0001, 16'h0001, 1'b0, "R2");
    check("R2", {co, s}, 17'h0_0002);
    apply(16'hAAAA, 16'h5555, 1'b1, "R3");
    check("R3", {co, s}, 17'h1_0000);
    apply(16'h5555, 16'hAAAA, 1'b0, "R3");
    check("R3", {co, s}, 17'h0_FFFF);
    apply(16'hFFFF, 16'h0001, 1'b0, "R4");
    check("R4", {co, s}, 17'h1_0000);
    apply(16'h8000, 16'h8000, 1'b0, "R5");
    check("R5", {16'h0, co}, 17'h1);
    apply(16'h8000, 16'h8000, 1'b1, "R5");
    check("R5", {co, s}, 17'h1_0001);
    apply(16'h7FFF, 16'h7FFF, 1'b1, "R6");
    check("R6", {co, s}, 17'h0_FFFF);
    apply(16'h00F0, 16'h0010, 1'b0, "R7");
    check("R7", {co, s}, 17'h0_0100);
    apply(16'h0F0F, 16'h00F1, 1'b1, "R7");
    check("R7", {co, s}, 17'h1_001 + 17'h0_0000);
    // R1 near-exhaustive sweep of two nibbles per operand, replicated across slices
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply({i[7:0], i[7:0]}, {j[7:0], ~j[7:0]}, i[0] ^ j[7], "R1");
      end
    end
    // R1 pseudo-random vectors
    lcg = 32'h1234_5678;
    for (int r = 0; r < 3000; r++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      apply(lcg[31:16], lcg[15:0] ^ lcg[23:8], lcg[7], "R1");
    end
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule